// File: doc/BRIEF.md
# Prioritised DMA Channel Grant Arbiter

This block decides which of several DMA channels the transfer engine serves next. A channel takes part only when it is enabled and raising a request. Each channel also has a 2-bit software level. The arbiter first finds the highest level held by any eligible channel. Among the channels at that level, the one with the smallest index wins. The winner is registered as a one-hot grant vector, together with its binary index and a valid flag.

A grant is single-owner. It stays fixed while the engine moves one data item for that channel, and it is released only when the engine pulses the completion input. In that completion cycle the arbiter compares the current requests again, so a new grant can follow without an idle cycle. Software may rewrite a level at any time. The new value counts only at the next arbitration.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset the grant vector is all zero, the index is zero and the valid output is low.
- R2: A channel is eligible only when both its request bit and its enable bit are 1. A requesting channel whose enable is 0 never receives a grant.
- R3: The level of channel i is ch_prio[2*i+1:2*i], encoded 00 low, 01 medium, 10 high, 11 ultra-high. The eligible channel with the numerically largest level wins.
- R4: When several eligible channels share the winning level, the one with the lowest channel index wins.
- R5: When no grant is active and a channel is eligible, the grant is registered on the next clock edge. Grant bit i is the only bit set, the index output equals i, and valid is high.
- R6: While valid is high and xfer_done is low, the grant and the index are held unchanged. This holds even if a request of higher level appears or the granted channel drops its request.
- R7: In a cycle where valid and xfer_done are both high, a fresh arbitration runs on the current inputs, and its result is registered on that edge. If no channel is eligible, valid goes low.
- R8: A change to any priority field while a grant is held does not alter that grant. The changed value is used at the next arbitration.
- R9: With no eligible channel and no active grant, the grant vector stays zero and valid stays low.
- R10: xfer_done is ignored when no grant is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_req | input | 7 | Request bit per channel |
| ch_en | input | 7 | Enable bit per channel |
| ch_prio | input | 14 | Packed 2-bit software level per channel |
| xfer_done | input | 1 | Engine finished the transfer for the granted channel |
| gnt | output | 7 | One-hot grant |
| gnt_idx | output | 3 | Index of the granted channel |
| gnt_valid | output | 1 | A grant is active |

## Verification
Release of a held grant and selection of its successor happen in the same clock cycle, because xfer_done opens arbitration at once. The bench raises xfer_done while requests of mixed levels are pending. In some of these cases the releasing channel is still requesting, and in others a priority field was rewritten during the hold. The grant seen on the next cycle must be the one that the current levels and the lowest-index rule select, and the old grant must never be kept by mistake. A completion pulse with nothing pending must leave the outputs idle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    localparam int DEF_CHANNELS = 7;
    localparam int DEF_LVL_W    = 2;

    typedef enum logic [1:0] {
        LVL_LOW   = 2'b00,
        LVL_MED   = 2'b01,
        LVL_HIGH  = 2'b10,
        LVL_ULTRA = 2'b11
    } sw_level_e;
endpackage

// File: rtl/dma_arb_toplvl.sv
// Stage one: highest software level present among eligible channels.
module dma_arb_toplvl #(
    parameter int NUM_CH = dma_arb_pkg::DEF_CHANNELS,
    parameter int LVL_W  = dma_arb_pkg::DEF_LVL_W
) (
    input  logic [NUM_CH-1:0]       elig,
    input  logic [NUM_CH*LVL_W-1:0] lvl,
    output logic [LVL_W-1:0]        top_lvl
);
    localparam int NUM_LVL = 1 << LVL_W;

    logic [NUM_LVL-1:0] lvl_seen;

    always_comb begin
        lvl_seen = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (elig[c]) lvl_seen[lvl[c*LVL_W +: LVL_W]] = 1'b1;
        end
        top_lvl = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (lvl_seen[l]) top_lvl = LVL_W'(l);
        end
    end
endmodule

// File: rtl/dma_arb_lowest.sv
// Stage two: lowest-index channel among the candidates at the top level.
module dma_arb_lowest #(
    parameter int NUM_CH = dma_arb_pkg::DEF_CHANNELS,
    parameter int IDX_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] cand,
    output logic              any,
    output logic [NUM_CH-1:0] onehot,
    output logic [IDX_W-1:0]  idx
);
    always_comb begin
        any    = |cand;
        onehot = cand & ((~cand) + NUM_CH'(1));
        idx    = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (cand[c]) idx = IDX_W'(c);
        end
    end
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter #(
    parameter int NUM_CH = dma_arb_pkg::DEF_CHANNELS,
    parameter int LVL_W  = dma_arb_pkg::DEF_LVL_W,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       ch_req,
    input  logic [NUM_CH-1:0]       ch_en,
    input  logic [NUM_CH*LVL_W-1:0] ch_prio,
    input  logic                    xfer_done,
    output logic [NUM_CH-1:0]       gnt,
    output logic [IDX_W-1:0]        gnt_idx,
    output logic                    gnt_valid
);
    typedef struct packed {
        logic [NUM_CH-1:0] gnt;
        logic [IDX_W-1:0]  idx;
        logic              valid;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [NUM_CH-1:0] elig;
    logic [LVL_W-1:0]  top_lvl;
    logic [NUM_CH-1:0] cand;
    logic              pick_any;
    logic [NUM_CH-1:0] pick_oh;
    logic [IDX_W-1:0]  pick_idx;

    assign elig = ch_req & ch_en;

    dma_arb_toplvl #(.NUM_CH(NUM_CH), .LVL_W(LVL_W)) u_toplvl (
        .elig    (elig),
        .lvl     (ch_prio),
        .top_lvl (top_lvl)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cand
        assign cand[c] = elig[c] && (ch_prio[c*LVL_W +: LVL_W] == top_lvl);
    end

    dma_arb_lowest #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_lowest (
        .cand   (cand),
        .any    (pick_any),
        .onehot (pick_oh),
        .idx    (pick_idx)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.valid || xfer_done) begin
            st_d.valid = pick_any;
            st_d.gnt   = pick_oh;
            st_d.idx   = pick_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gnt       = st_q.gnt;
    assign gnt_idx   = st_q.idx;
    assign gnt_valid = st_q.valid;

    // R5: the index names the single set grant bit
    a_r5_idx_matches: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> ($onehot(gnt) && gnt[gnt_idx]));

    // R9: no grant bit without valid
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_valid |-> (gnt == '0));

    // R6: held grant is stable until completion
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !xfer_done) |=> (gnt_valid && $stable(gnt) && $stable(gnt_idx)));

    // R2: a new grant always goes to a channel that was eligible
    a_r2_from_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        ((!gnt_valid || xfer_done) && (|elig)) |=> (gnt_valid && (|(gnt & $past(elig)))));

    // R7: completion with nothing eligible leaves the arbiter idle
    a_r7_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_valid && xfer_done) && !(|elig)) |=> !gnt_valid);

    // R10: with no grant, no eligible channel keeps it idle regardless of xfer_done
    a_r10_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_valid && !(|elig)) |=> !gnt_valid);
endmodule

// File: tb/tb_dma_prio_arbiter.sv
module tb_dma_prio_arbiter;
    localparam int NCH = 7;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] req = '0;
    logic [NCH-1:0] en = '0;
    logic [2*NCH-1:0] prio = '0;
    logic           done = 1'b0;
    logic [NCH-1:0] gnt;
    logic [2:0]     gnt_idx;
    logic           gnt_valid;

    int n_checks = 0;
    int n_errs = 0;

    always #5 clk = ~clk;

    dma_prio_arbiter dut (
        .clk(clk), .rst_n(rst_n), .ch_req(req), .ch_en(en), .ch_prio(prio),
        .xfer_done(done), .gnt(gnt), .gnt_idx(gnt_idx), .gnt_valid(gnt_valid)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_lvl(input int ch, input logic [1:0] l);
        prio[2*ch +: 2] = l;
    endtask

    // exp < 0 means no grant expected
    task automatic expect_grant(input string tag, input int exp);
        int act;
        n_checks++;
        act = gnt_valid ? int'(gnt_idx) : -1;
        if (exp < 0) begin
            if (gnt_valid || gnt != '0) begin
                n_errs++;
                $display("FAIL %s: valid=%0b gnt=%b expected idle", tag, gnt_valid, gnt);
            end
        end else if (!gnt_valid || gnt != NCH'(1 << exp) || gnt_idx != 3'(exp)) begin
            n_errs++;
            $display("FAIL %s: actual ch %0d gnt=%b, expected ch %0d", tag, act, gnt, exp);
        end
    endtask

    task automatic clear_all();
        req = '0; done = 1'b1; step();
        done = 1'b0; step();
    endtask

    function automatic int ref_win(input logic [NCH-1:0] r, input logic [NCH-1:0] e,
                                   input logic [2*NCH-1:0] p);
        int best = -1;
        for (int c = 0; c < NCH; c++) begin
            if (r[c] && e[c]) begin
                if (best < 0 || p[2*c +: 2] > p[2*best +: 2]) best = c;
            end
        end
        return best;
    endfunction

    task automatic t_reset();
        expect_grant("R1 reset", -1);
        n_checks++;
        if (gnt_idx != 3'd0) begin
            n_errs++;
            $display("FAIL R1 idx: actual %0d expected 0", gnt_idx);
        end
    endtask

    task automatic t_idle();
        done = 1'b1; step(); step();
        expect_grant("R10 done with no grant", -1);
        done = 1'b0; step();
        expect_grant("R9 no request", -1);
    endtask

    task automatic t_single();
        en = '1;
        for (int c = 0; c < NCH; c++) begin
            req = NCH'(1 << c); step();
            expect_grant("R5 single requester", c);
            clear_all();
        end
    endtask

    task automatic t_disabled();
        en = 7'b1111011; req = 7'b0000100; set_lvl(2, 2'b11); step(); step();
        expect_grant("R2 disabled requester", -1);
        req = 7'b0100100; set_lvl(5, 2'b00); step();
        expect_grant("R2 disabled high level skipped", 5);
        clear_all(); en = '1; prio = '0;
    endtask

    task automatic t_levels();
        set_lvl(0, 2'b00); set_lvl(3, 2'b01); set_lvl(6, 2'b10);
        req = 7'b1001001; step();
        expect_grant("R3 high beats medium and low", 6);
        clear_all();
        set_lvl(4, 2'b11); req = 7'b1011001; step();
        expect_grant("R3 ultra-high wins", 4);
        clear_all(); prio = '0;
    endtask

    task automatic t_tie();
        req = '1; step();
        expect_grant("R4 all low, lowest index", 0);
        clear_all();
        set_lvl(2, 2'b10); set_lvl(5, 2'b10); set_lvl(6, 2'b10);
        req = 7'b1100101; step();
        expect_grant("R4 tie at high", 2);
        clear_all(); prio = '0;
    endtask

    task automatic t_hold();
        req = 7'b1000000; step();
        expect_grant("R5 grant ch6", 6);
        req = 7'b1000011; set_lvl(0, 2'b11); step(); step();
        expect_grant("R6 held against higher request", 6);
        req = 7'b0000011; step();
        expect_grant("R6 held after request drop", 6);
        done = 1'b1; step(); done = 1'b0;
        expect_grant("R7 re-arbitrate on done", 0);
        clear_all(); prio = '0;
    endtask

    task automatic t_back_to_back();
        set_lvl(1, 2'b01); req = 7'b0000010; step();
        expect_grant("R5 grant ch1", 1);
        req = 7'b0001010; set_lvl(3, 2'b01); done = 1'b1; step();
        expect_grant("R7 completion picks ch1 again by index", 1);
        set_lvl(3, 2'b10); step();
        expect_grant("R7 completion picks raised ch3", 3);
        req = '0; step(); done = 1'b0;
        expect_grant("R7 completion with nothing pending", -1);
        step();
        expect_grant("R9 idle after release", -1);
        prio = '0;
    endtask

    task automatic t_prio_change();
        set_lvl(2, 2'b01); set_lvl(4, 2'b00); req = 7'b0010100; step();
        expect_grant("R8 initial grant", 2);
        set_lvl(4, 2'b11); set_lvl(2, 2'b00); step(); step();
        expect_grant("R8 level change mid-grant", 2);
        done = 1'b1; step(); done = 1'b0;
        expect_grant("R8 new level used next", 4);
        clear_all(); prio = '0;
    endtask

    task automatic t_sweep();
        logic [31:0] s = 32'h1234_5678;
        for (int k = 0; k < 40; k++) begin
            s = s * 32'd1103515245 + 32'd12345;
            req = s[22:16]; en = s[29:23] | 7'b0010001;
            prio = {s[13:0]} ^ {s[31:30], s[11:0]};
            done = 1'b1; step();
            expect_grant("R3 R4 sweep", ref_win(req, en, prio));
        end
        done = 1'b0; en = '1; prio = '0;
        clear_all();
    endtask

    initial begin
        step(); step();
        t_reset();
        rst_n = 1'b1; step();
        t_idle();
        t_single();
        t_disabled();
        t_levels();
        t_tie();
        t_hold();
        t_back_to_back();
        t_prio_change();
        t_sweep();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule